// File: doc/BRIEF.md
# SECDED Memory Word Guard

This unit sits between a memory controller's request side and its storage. On the write path it turns each data word into a codeword with a single-error-correct, double-error-detect code: a Hamming code with an added overall parity bit. On the read path it checks each incoming codeword. It repairs any one flipped bit and returns the repaired data. When two bits are flipped, it raises an error flag in the same cycle as the read-valid strobe. Each path is registered once, so each adds exactly one clock of latency.

Detected errors feed a small register file. It holds sticky status bits, separate saturating counters for correctable and uncorrectable errors, the address of the most recent bad read, and a sticky interrupt. A write to the status register clears the status bits, both counters and the interrupt. A fault-injection register can flip one or two chosen codeword bits on every write, so the correction and detection logic can be exercised with real stored data.

Top module: `ecc_guard`

## Requirements
- R1: A write presented with `wr_valid_i` high appears one cycle later on `wr_valid_o`, with `wr_addr_o` equal to the presented address and `wr_code_o` holding the codeword. `wr_valid_o` is low in any cycle that follows a cycle with `wr_valid_i` low.
- R2: A read presented with `rd_valid_i` high gives `rd_valid_o` high one cycle later. If the codeword is intact, `rd_data_o` equals the original data and `rd_err_o` is low. `rd_valid_o` is low in any cycle that follows a cycle with `rd_valid_i` low.
- R3: A codeword with exactly one flipped bit, at any of the `CODE_W` positions (check bits included), returns the original data with `rd_err_o` low.
- R4: A codeword with exactly two flipped bits gives `rd_err_o` high, in the same cycle as `rd_valid_o`. `rd_err_o` is never high while `rd_valid_o` is low. A nonzero syndrome that names no codeword position is also reported as uncorrectable.
- R5: `irq_o` goes high in the same cycle as the `rd_valid_o` of the first erroneous read. It stays high until a write to the status register.
- R6: Register 1 counts single-bit errors and register 2 counts double-bit errors. Each counter saturates at 2^`CNT_W`-1 and never wraps.
- R7: Register 0 bit 0 is set by a single-bit error and bit 1 by a double-bit error; both bits are sticky. Register 3 holds the address of the last read that had any error.
- R8: A write to register 0, whatever the data, clears the status bits, both counters and `irq_o`. If an error is detected in the same cycle, the error wins.
- R9: Register 4 controls fault injection. Bits [7:0] give position A and bits [15:8] give position B. When bit 16 is set, codeword bit A is flipped on writes. When bit 17 is set, bits A and B are both flipped on writes. The register reads back as written (bits [17:0]).
- R10: While `rd_valid_i` is low, `rd_code_i` has no effect on the counters, the status bits or `irq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_valid_i | input | 1 | Write request strobe |
| wr_addr_i | input | ADDR_W | Write address |
| wr_data_i | input | DATA_W | Write data |
| wr_valid_o | output | 1 | Encoded write strobe |
| wr_addr_o | output | ADDR_W | Registered write address |
| wr_code_o | output | CODE_W | Encoded codeword, with injected faults applied |
| rd_valid_i | input | 1 | Read codeword strobe |
| rd_addr_i | input | ADDR_W | Address of the read codeword |
| rd_code_i | input | CODE_W | Codeword read from memory |
| rd_valid_o | output | 1 | Read data strobe |
| rd_data_o | output | DATA_W | Corrected read data |
| rd_err_o | output | 1 | Uncorrectable error, aligned with rd_valid_o |
| irq_o | output | 1 | Sticky error interrupt |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register index |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i |

## Verification
Random data words are first read back clean, which shows that encode and decode are inverse and that nothing is flagged. A directed sweep then flips every codeword position in turn, so an error in a data bit, a Hamming check bit or the overall parity bit is each seen to be corrected and counted as single. Random pairs of distinct flipped positions separate double errors from single ones: a decoder that confused them would return wrong data or miss the flag. Further patterns cover injected faults, corrupt codewords with the strobe low, and a long run of single errors that shows the counter saturating rather than wrapping.

// File: rtl/ecc_guard_pkg.sv
package ecc_guard_pkg;
  localparam int REG_W = 32;

  localparam logic [2:0] REG_STATUS = 3'd0;
  localparam logic [2:0] REG_SBE    = 3'd1;
  localparam logic [2:0] REG_DBE    = 3'd2;
  localparam logic [2:0] REG_EADDR  = 3'd3;
  localparam logic [2:0] REG_INJECT = 3'd4;

  localparam int INJ_W = 18;

  typedef struct packed {
    logic       dbl_en;
    logic       sgl_en;
    logic [7:0] pos_b;
    logic [7:0] pos_a;
  } inj_ctrl_t;

  // smallest p with 2^p >= data + p + 1
  function automatic int parity_bits(input int dw);
    int p;
    p = 1;
    while ((1 << p) < dw + p + 1) p++;
    return p;
  endfunction
endpackage

// File: rtl/ecc_enc.sv
module ecc_enc #(
  parameter int DATA_W = 32,
  parameter int P      = 6,
  parameter int CODE_W = DATA_W + P + 1
) (
  input  logic [DATA_W-1:0] data_i,
  output logic [CODE_W-1:0] code_o
);
  localparam int N = DATA_W + P;

  logic [N:1] ham;

  always_comb begin
    int d;
    ham = '0;
    d   = 0;
    // data fills non-power-of-two positions
    for (int j = 1; j <= N; j++) begin
      if ((j & (j - 1)) != 0) begin
        ham[j] = data_i[d];
        d++;
      end
    end
    for (int p = 0; p < P; p++) begin
      for (int j = 1; j <= N; j++) begin
        if ((((j >> p) & 1) == 1) && (j != (1 << p))) ham[1 << p] = ham[1 << p] ^ ham[j];
      end
    end
    code_o = {^ham, ham};
  end
endmodule

// File: rtl/ecc_dec.sv
module ecc_dec #(
  parameter int DATA_W = 32,
  parameter int P      = 6,
  parameter int CODE_W = DATA_W + P + 1
) (
  input  logic [CODE_W-1:0] code_i,
  output logic [DATA_W-1:0] data_o,
  output logic              single_o,
  output logic              double_o
);
  localparam int N = DATA_W + P;

  logic [N:1]   ham;
  logic [P-1:0] syn;
  logic         par;

  always_comb begin
    int d;
    ham = code_i[N-1:0];
    syn = '0;
    for (int p = 0; p < P; p++) begin
      for (int j = 1; j <= N; j++) begin
        if (((j >> p) & 1) == 1) syn[p] = syn[p] ^ ham[j];
      end
    end
    par      = ^code_i;
    single_o = 1'b0;
    double_o = 1'b0;
    if (syn != '0) begin
      if (par && (int'(syn) <= N)) begin
        single_o = 1'b1;
        for (int j = 1; j <= N; j++) begin
          if (j == int'(syn)) ham[j] = ~ham[j];
        end
      end else begin
        double_o = 1'b1;
      end
    end else if (par) begin
      single_o = 1'b1;  // overall parity bit itself flipped
    end
    data_o = '0;
    d      = 0;
    for (int j = 1; j <= N; j++) begin
      if ((j & (j - 1)) != 0) begin
        data_o[d] = ham[j];
        d++;
      end
    end
  end
endmodule

// File: rtl/ecc_regs.sv
module ecc_regs
  import ecc_guard_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic [2:0]        reg_addr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  input  logic              evt_valid_i,
  input  logic              evt_single_i,
  input  logic              evt_double_i,
  input  logic [ADDR_W-1:0] evt_addr_i,
  output logic [CNT_W-1:0]  sbe_cnt_o,
  output logic [CNT_W-1:0]  dbe_cnt_o,
  output logic              irq_o,
  output inj_ctrl_t         inj_o
);
  logic              st_single, st_double;
  logic [CNT_W-1:0]  sbe_cnt, dbe_cnt;
  logic [ADDR_W-1:0] err_addr;
  logic              irq_q;
  inj_ctrl_t         inj_q;
  logic              clr;
  logic              hit_s, hit_d;
  logic              unused_wdata;

  assign unused_wdata = ^reg_wdata_i[REG_W-1:INJ_W];
  assign clr   = reg_wr_i && (reg_addr_i == REG_STATUS);
  assign hit_s = evt_valid_i && evt_single_i;
  assign hit_d = evt_valid_i && evt_double_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_single <= 1'b0;
      st_double <= 1'b0;
      sbe_cnt   <= '0;
      dbe_cnt   <= '0;
      err_addr  <= '0;
      irq_q     <= 1'b0;
      inj_q     <= '0;
    end else begin
      if (clr) begin
        st_single <= 1'b0;
        st_double <= 1'b0;
        sbe_cnt   <= '0;
        dbe_cnt   <= '0;
        irq_q     <= 1'b0;
      end
      if (reg_wr_i && (reg_addr_i == REG_INJECT)) inj_q <= reg_wdata_i[INJ_W-1:0];
      // set wins over clear
      if (hit_s) begin
        st_single <= 1'b1;
        sbe_cnt   <= clr ? CNT_W'(1) : ((sbe_cnt != '1) ? sbe_cnt + CNT_W'(1) : sbe_cnt);
      end
      if (hit_d) begin
        st_double <= 1'b1;
        dbe_cnt   <= clr ? CNT_W'(1) : ((dbe_cnt != '1) ? dbe_cnt + CNT_W'(1) : dbe_cnt);
      end
      if (hit_s || hit_d) begin
        irq_q    <= 1'b1;
        err_addr <= evt_addr_i;
      end
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      REG_STATUS: reg_rdata_o[1:0]        = {st_double, st_single};
      REG_SBE:    reg_rdata_o[CNT_W-1:0]  = sbe_cnt;
      REG_DBE:    reg_rdata_o[CNT_W-1:0]  = dbe_cnt;
      REG_EADDR:  reg_rdata_o[ADDR_W-1:0] = err_addr;
      REG_INJECT: reg_rdata_o[INJ_W-1:0]  = inj_q;
      default:    reg_rdata_o = '0;
    endcase
  end

  assign sbe_cnt_o = sbe_cnt;
  assign dbe_cnt_o = dbe_cnt;
  assign irq_o     = irq_q;
  assign inj_o     = inj_q;
endmodule

// File: rtl/ecc_guard.sv
module ecc_guard
  import ecc_guard_pkg::*;
#(
  parameter int  DATA_W = 32,
  parameter int  ADDR_W = 16,
  parameter int  CNT_W  = 8,
  localparam int P      = parity_bits(DATA_W),
  localparam int CODE_W = DATA_W + P + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_valid_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              wr_valid_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [CODE_W-1:0] wr_code_o,
  input  logic              rd_valid_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic [CODE_W-1:0] rd_code_i,
  output logic              rd_valid_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_err_o,
  output logic              irq_o,
  input  logic              reg_wr_i,
  input  logic [2:0]        reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o
);
  logic [CODE_W-1:0] enc_code, inj_mask;
  logic [DATA_W-1:0] dec_data;
  logic              dec_single, dec_double;
  logic [CNT_W-1:0]  sbe_cnt, dbe_cnt;
  inj_ctrl_t         inj;

  ecc_enc #(.DATA_W(DATA_W), .P(P), .CODE_W(CODE_W)) u_enc (
    .data_i (wr_data_i),
    .code_o (enc_code)
  );

  ecc_dec #(.DATA_W(DATA_W), .P(P), .CODE_W(CODE_W)) u_dec (
    .code_i   (rd_code_i),
    .data_o   (dec_data),
    .single_o (dec_single),
    .double_o (dec_double)
  );

  ecc_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .reg_wr_i     (reg_wr_i),
    .reg_addr_i   (reg_addr_i),
    .reg_wdata_i  (reg_wdata_i),
    .reg_rdata_o  (reg_rdata_o),
    .evt_valid_i  (rd_valid_i),
    .evt_single_i (dec_single),
    .evt_double_i (dec_double),
    .evt_addr_i   (rd_addr_i),
    .sbe_cnt_o    (sbe_cnt),
    .dbe_cnt_o    (dbe_cnt),
    .irq_o        (irq_o),
    .inj_o        (inj)
  );

  for (genvar g = 0; g < CODE_W; g++) begin : g_inj
    assign inj_mask[g] = ((inj.sgl_en || inj.dbl_en) && (inj.pos_a == 8'(g)))
                       || (inj.dbl_en && (inj.pos_b == 8'(g)));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_valid_o <= 1'b0;
      wr_addr_o  <= '0;
      wr_code_o  <= '0;
      rd_valid_o <= 1'b0;
      rd_data_o  <= '0;
      rd_err_o   <= 1'b0;
    end else begin
      wr_valid_o <= wr_valid_i;
      wr_addr_o  <= wr_addr_i;
      wr_code_o  <= enc_code ^ inj_mask;
      rd_valid_o <= rd_valid_i;
      rd_data_o  <= dec_data;
      rd_err_o   <= rd_valid_i && dec_double;
    end
  end
endmodule

// File: rtl/ecc_guard_chk.sv
module ecc_guard_chk
  import ecc_guard_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_valid_i,
  input logic [ADDR_W-1:0] wr_addr_i,
  input logic              wr_valid_o,
  input logic [ADDR_W-1:0] wr_addr_o,
  input logic              rd_valid_i,
  input logic              rd_valid_o,
  input logic              rd_err_o,
  input logic              irq_o,
  input logic              reg_wr_i,
  input logic [2:0]        reg_addr_i,
  input logic [CNT_W-1:0]  sbe_cnt,
  input logic [CNT_W-1:0]  dbe_cnt
);
  logic clr;
  assign clr = reg_wr_i && (reg_addr_i == REG_STATUS);

  a_r1_wr_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_i |=> (wr_valid_o && (wr_addr_o == $past(wr_addr_i))));

  a_r1_wr_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_valid_i |=> !wr_valid_o);

  a_r2_rd_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_i |=> rd_valid_o);

  a_r2_rd_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_valid_i |=> !rd_valid_o);

  a_r4_err_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_err_o |-> rd_valid_o);

  a_r5_irq_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !clr) |=> irq_o);

  a_r6_no_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr |=> ((sbe_cnt >= $past(sbe_cnt)) && (dbe_cnt >= $past(dbe_cnt))));

  a_r8_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr && !rd_valid_i) |=> ((sbe_cnt == '0) && (dbe_cnt == '0) && !irq_o));

  a_r10_idle_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_valid_i && !clr) |=> ($stable(sbe_cnt) && $stable(dbe_cnt) && $stable(irq_o)));
endmodule

bind ecc_guard ecc_guard_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_valid_i (wr_valid_i),
  .wr_addr_i  (wr_addr_i),
  .wr_valid_o (wr_valid_o),
  .wr_addr_o  (wr_addr_o),
  .rd_valid_i (rd_valid_i),
  .rd_valid_o (rd_valid_o),
  .rd_err_o   (rd_err_o),
  .irq_o      (irq_o),
  .reg_wr_i   (reg_wr_i),
  .reg_addr_i (reg_addr_i),
  .sbe_cnt    (sbe_cnt),
  .dbe_cnt    (dbe_cnt)
);

// File: tb/ecc_guard_test.sv
module ecc_guard_test;
  localparam int DATA_W  = 32;
  localparam int ADDR_W  = 16;
  localparam int CODE_W  = 39;
  localparam int CNT_MAX = 255;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wr_valid = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [DATA_W-1:0] wr_data = '0;
  logic              wr_valid_o;
  logic [ADDR_W-1:0] wr_addr_o;
  logic [CODE_W-1:0] wr_code_o;
  logic              rd_valid = 1'b0;
  logic [ADDR_W-1:0] rd_addr = '0;
  logic [CODE_W-1:0] rd_code = '0;
  logic              rd_valid_o;
  logic [DATA_W-1:0] rd_data_o;
  logic              rd_err_o;
  logic              irq_o;
  logic              reg_wr = 1'b0;
  logic [2:0]        reg_addr = '0;
  logic [31:0]       reg_wdata = '0;
  logic [31:0]       reg_rdata;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  ecc_guard uut (
    .clk_i(clk), .rst_ni(rst_n),
    .wr_valid_i(wr_valid), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .wr_valid_o(wr_valid_o), .wr_addr_o(wr_addr_o), .wr_code_o(wr_code_o),
    .rd_valid_i(rd_valid), .rd_addr_i(rd_addr), .rd_code_i(rd_code),
    .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o), .rd_err_o(rd_err_o),
    .irq_o(irq_o),
    .reg_wr_i(reg_wr), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata)
  );

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic do_write(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d,
                          output logic [CODE_W-1:0] code);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    check("R1 wr_valid_o", 64'(wr_valid_o), 64'd1);
    check("R1 wr_addr_o", 64'(wr_addr_o), 64'(a));
    code = wr_code_o;
    wr_valid = 1'b0;
  endtask

  task automatic do_read(input logic [ADDR_W-1:0] a, input logic [CODE_W-1:0] code,
                         output logic [DATA_W-1:0] d, output logic err, output logic vld);
    @(negedge clk);
    rd_valid = 1'b1; rd_addr = a; rd_code = code;
    @(negedge clk);
    d = rd_data_o; err = rd_err_o; vld = rd_valid_o;
    rd_valid = 1'b0;
  endtask

  function automatic logic [CODE_W-1:0] bit_at(input int b);
    return CODE_W'(1) << b;
  endfunction

  initial begin
    repeat (25000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0]       r;
    logic [CODE_W-1:0] c, c0;
    logic [DATA_W-1:0] d, q;
    logic [ADDR_W-1:0] a;
    logic              e, v;
    void'($urandom(32'd20240611));

    repeat (3) @(negedge clk);
    // reset state
    check("R2 reset rd_valid_o", 64'(rd_valid_o), 64'd0);
    check("R1 reset wr_valid_o", 64'(wr_valid_o), 64'd0);
    check("R5 reset irq_o", 64'(irq_o), 64'd0);
    rst_n = 1'b1;
    reg_read(3'd0, r); check("R7 reset status", 64'(r), 64'd0);
    reg_read(3'd1, r); check("R6 reset sbe", 64'(r), 64'd0);

    // R1/R2 clean round trips, plus corner data patterns
    for (int i = 0; i < 40; i++) begin
      a = ADDR_W'($urandom);
      d = (i == 0) ? '0 : (i == 1) ? '1 : $urandom;
      do_write(a, d, c);
      do_read(a, c, q, e, v);
      check("R2 clean data", 64'(q), 64'(d));
      check("R2 clean err", 64'(e), 64'd0);
      check("R2 rd_valid_o", 64'(v), 64'd1);
    end
    @(negedge clk);
    check("R2 rd_valid_o drops", 64'(rd_valid_o), 64'd0);
    check("R1 wr_valid_o drops", 64'(wr_valid_o), 64'd0);
    check("R5 no irq on clean", 64'(irq_o), 64'd0);

    // R3: sweep every single-bit position
    for (int b = 0; b < CODE_W; b++) begin
      a = ADDR_W'(16'h1000 + b);
      d = $urandom;
      do_write(a, d, c);
      do_read(a, c ^ bit_at(b), q, e, v);
      check("R3 corrected data", 64'(q), 64'(d));
      check("R3 no err flag", 64'(e), 64'd0);
      if (b == 0) check("R5 irq with first error", 64'(irq_o), 64'd1);
    end
    reg_read(3'd1, r); check("R6 sbe count", 64'(r), 64'(CODE_W));
    reg_read(3'd2, r); check("R6 dbe count", 64'(r), 64'd0);
    reg_read(3'd0, r); check("R7 status single", 64'(r), 64'd1);
    reg_read(3'd3, r); check("R7 err addr", 64'(r), 64'(16'h1000 + CODE_W - 1));
    check("R5 irq held", 64'(irq_o), 64'd1);

    // R8 clear
    reg_write(3'd0, 32'h0);
    check("R8 irq cleared", 64'(irq_o), 64'd0);
    reg_read(3'd0, r); check("R8 status cleared", 64'(r), 64'd0);
    reg_read(3'd1, r); check("R8 sbe cleared", 64'(r), 64'd0);

    // R4: random double flips
    for (int i = 0; i < 30; i++) begin
      int b1, b2;
      b1 = int'($urandom % CODE_W);
      b2 = (b1 + 1 + int'($urandom % (CODE_W - 1))) % CODE_W;
      a = ADDR_W'(16'h2000 + i);
      d = $urandom;
      do_write(a, d, c);
      do_read(a, c ^ bit_at(b1) ^ bit_at(b2), q, e, v);
      check("R4 err flag", 64'(e), 64'd1);
      check("R4 err with valid", 64'(v), 64'd1);
    end
    reg_read(3'd2, r); check("R6 dbe count", 64'(r), 64'd30);
    reg_read(3'd1, r); check("R6 sbe untouched", 64'(r), 64'd0);
    reg_read(3'd0, r); check("R7 status double", 64'(r), 64'd2);
    reg_read(3'd3, r); check("R7 err addr double", 64'(r), 64'(16'h2000 + 29));

    // R10: corrupt codeword without strobe
    reg_write(3'd0, 32'hFFFF_FFFF);
    @(negedge clk);
    rd_code = '1 ^ bit_at(3); rd_addr = 16'hBEEF;
    repeat (4) @(negedge clk);
    check("R10 irq unaffected", 64'(irq_o), 64'd0);
    check("R10 no valid", 64'(rd_valid_o), 64'd0);
    reg_read(3'd1, r); check("R10 sbe unaffected", 64'(r), 64'd0);
    reg_read(3'd2, r); check("R10 dbe unaffected", 64'(r), 64'd0);
    reg_read(3'd0, r); check("R10 status unaffected", 64'(r), 64'd0);

    // R9: fault injection
    d = 32'hA5C3_0F96;
    do_write(16'h0300, d, c0);
    reg_write(3'd4, 32'h0001_0005);
    reg_read(3'd4, r); check("R9 inject readback", 64'(r), 64'h0001_0005);
    do_write(16'h0301, d, c);
    check("R9 single flip", 64'(c ^ c0), 64'(bit_at(5)));
    do_read(16'h0301, c, q, e, v);
    check("R9 single corrected", 64'(q), 64'(d));
    check("R9 single no err", 64'(e), 64'd0);
    reg_write(3'd4, 32'h0002_1403);
    do_write(16'h0302, d, c);
    check("R9 double flip", 64'(c ^ c0), 64'(bit_at(3) ^ bit_at(20)));
    do_read(16'h0302, c, q, e, v);
    check("R9 double err", 64'(e), 64'd1);
    reg_write(3'd4, 32'h0);
    do_write(16'h0303, d, c);
    check("R9 inject off", 64'(c ^ c0), 64'd0);
    reg_read(3'd1, r); check("R9 sbe from injection", 64'(r), 64'd1);
    reg_read(3'd2, r); check("R9 dbe from injection", 64'(r), 64'd1);

    // R6 saturation
    reg_write(3'd0, 32'h0);
    for (int i = 0; i < CNT_MAX + 6; i++) begin
      do_read(16'h0400, c0 ^ bit_at(i % CODE_W), q, e, v);
      if (q !== d) check("R3 corrected in run", 64'(q), 64'(d));
    end
    reg_read(3'd1, r); check("R6 sbe saturates", 64'(r), 64'(CNT_MAX));
    reg_read(3'd2, r); check("R6 dbe stays zero", 64'(r), 64'd0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule